// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Victim Buffer

This block is a read-only first-level cache whose main store is direct-mapped. Each set holds one line. Next to it sits a small fully-associative victim buffer that keeps lines recently pushed out of the main store. A processor request goes first to the main array. When that misses, the victim buffer is searched. A victim hit exchanges the buffered line with the conflicting main line and returns the data one cycle later than a main hit. When both miss, the block issues a refill request to the next memory level. When the refill returns, the fetched line is installed in the main array and the displaced valid line moves into the victim buffer.

A line is one data word, and addresses are line addresses. The low `IDX_W` bits select the set and the upper bits form the tag. Only one request is in flight at a time. `stall` is high from the cycle after acceptance up to and including the response cycle, and new requests are accepted only while `stall` is low.

Top module: `vc_cache`

## Requirements
- R1: After reset, `stall`, `resp_valid` and `refill_req_valid` are low, and every main and victim entry is invalid, so the first access to any address misses both structures.
- R2: A request accepted at a clock edge that hits the main array raises `resp_valid` with the stored data in the cycle right after that edge.
- R3: The victim buffer has `VB_N` entries (1 to 5). Each entry holds a full line address and a valid bit, all entries are compared at once, and at most one entry matches a given address.
- R4: A request that misses the main array but hits the victim buffer responds exactly one cycle later than a main hit, and it issues no refill request.
- R5: On a victim hit, the requested line and the conflicting main line exchange places. A repeat of the request then hits the main array, and the line that was displaced becomes a victim hit.
- R6: A request that misses both structures raises `refill_req_valid` with the request's line address from the second cycle after acceptance. It holds both until `refill_resp_valid`, and it returns the refill data on `resp_data` in that same cycle.
- R7: On a double miss, the valid line leaving the main array is written into the victim buffer, and the fetched line goes only into the main array.
- R8: An invalid main line being displaced by a refill takes no victim-buffer entry.
- R9: An empty victim entry is used before any valid entry is evicted. When the buffer is full, the least recently used entry is replaced, where both insertion and a swap count as a use.
- R10: While `stall` is high, `req_valid` is ignored and the cache contents are unchanged by it. `stall` returns low in the cycle after the response.
- R11: The main array is direct-mapped: the set is `addr[IDX_W-1:0]`, including the highest set and the all-ones tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request, taken when `stall` is low |
| req_addr | input | AW | Requested line address |
| stall | output | 1 | A request is in flight |
| resp_valid | output | 1 | Response data valid this cycle |
| resp_data | output | DW | Response data |
| refill_req_valid | output | 1 | Line request to the next level |
| refill_req_addr | output | AW | Line address of the refill |
| refill_resp_valid | input | 1 | Refill data valid |
| refill_resp_data | input | DW | Refill data |

## Verification
The hardest state to reach is a full victim buffer whose recency order decides whether an old conflicting line survives. Only a run of more than `VB_N` distinct conflicts on a few sets, mixed with swaps that reorder recency, gets there. The bench plays a directed conflict series on one set and then a long pseudo-random run over a small pool of tags and two sets. A queue model in the bench predicts a main hit, a victim hit or a miss for every access, and checks latency, data and the refill handshake cycle by cycle. Stray requests are driven while the block stalls, to show that they leave no trace.

// File: rtl/vc_cache.sv
module vc_cache #(
  parameter int AW    = 12,
  parameter int IDX_W = 3,
  parameter int DW    = 32,
  parameter int VB_N  = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [AW-1:0] req_addr,
  output logic          stall,
  output logic          resp_valid,
  output logic [DW-1:0] resp_data,
  output logic          refill_req_valid,
  output logic [AW-1:0] refill_req_addr,
  input  logic          refill_resp_valid,
  input  logic [DW-1:0] refill_resp_data
);
  localparam int SETS = 1 << IDX_W;
  localparam int TW   = AW - IDX_W;
  localparam int WW   = (VB_N > 1) ? $clog2(VB_N) : 1;
  localparam logic [WW-1:0] OLDEST = WW'(VB_N - 1);

  typedef enum logic [1:0] {S_IDLE, S_CHECK, S_SWAP, S_FILL} st_t;
  st_t st;

  logic [AW-1:0] cur;
  logic [WW-1:0] hw_q;

  logic          m_v [SETS];
  logic [TW-1:0] m_t [SETS];
  logic [DW-1:0] m_d [SETS];

  logic          vb_v   [VB_N];
  logic [AW-1:0] vb_a   [VB_N];
  logic [DW-1:0] vb_d   [VB_N];
  logic [WW-1:0] vb_age [VB_N];

  wire [IDX_W-1:0] idx = cur[IDX_W-1:0];
  wire [TW-1:0]    tg  = cur[AW-1:IDX_W];
  wire main_hit = m_v[idx] && (m_t[idx] == tg);

  logic [VB_N-1:0] vb_hit, vb_old;
  for (genvar i = 0; i < VB_N; i++) begin : g_cmp
    assign vb_hit[i] = vb_v[i] && (vb_a[i] == cur);
    assign vb_old[i] = vb_v[i] && (vb_age[i] == OLDEST);
  end

  logic [WW-1:0] hit_way, free_way, lru_way, ins_way, t_way;
  logic any_free;
  always_comb begin
    hit_way = '0; free_way = '0; lru_way = '0; any_free = 1'b0;
    for (int i = VB_N - 1; i >= 0; i--) begin
      if (vb_hit[i]) hit_way = WW'(i);
      if (vb_old[i]) lru_way = WW'(i);
      if (!vb_v[i]) begin free_way = WW'(i); any_free = 1'b1; end
    end
  end
  assign ins_way = any_free ? free_way : lru_way;

  wire fill_done = (st == S_FILL) && refill_resp_valid;
  wire push      = fill_done && m_v[idx];
  wire touch     = (st == S_SWAP) || push;
  assign t_way   = (st == S_SWAP) ? hw_q : ins_way;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      hw_q <= '0;
      for (int s = 0; s < SETS; s++) begin
        m_v[s] <= 1'b0; m_t[s] <= '0; m_d[s] <= '0;
      end
      for (int j = 0; j < VB_N; j++) begin
        vb_v[j] <= 1'b0; vb_a[j] <= '0; vb_d[j] <= '0; vb_age[j] <= '0;
      end
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin cur <= req_addr; st <= S_CHECK; end
        S_CHECK:
          if (main_hit)     st <= S_IDLE;
          else if (|vb_hit) begin hw_q <= hit_way; st <= S_SWAP; end
          else              st <= S_FILL;
        S_SWAP: begin
          m_t[idx]   <= vb_a[hw_q][AW-1:IDX_W];
          m_d[idx]   <= vb_d[hw_q];
          vb_a[hw_q] <= {m_t[idx], idx};
          vb_d[hw_q] <= m_d[idx];
          st <= S_IDLE;
        end
        S_FILL: if (refill_resp_valid) begin
          m_v[idx] <= 1'b1;
          m_t[idx] <= tg;
          m_d[idx] <= refill_resp_data;
          if (m_v[idx]) begin
            vb_v[ins_way] <= 1'b1;
            vb_a[ins_way] <= {m_t[idx], idx};
            vb_d[ins_way] <= m_d[idx];
          end
          st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
      if (touch)
        for (int j = 0; j < VB_N; j++) begin
          if (WW'(j) == t_way) vb_age[j] <= '0;
          else if (vb_v[j] && (!vb_v[t_way] || vb_age[j] < vb_age[t_way]))
            vb_age[j] <= vb_age[j] + WW'(1);
        end
    end
  end

  assign stall            = (st != S_IDLE);
  assign resp_valid       = ((st == S_CHECK) && main_hit) || (st == S_SWAP) || fill_done;
  assign resp_data        = (st == S_CHECK) ? m_d[idx] :
                            (st == S_SWAP)  ? vb_d[hw_q] : refill_resp_data;
  assign refill_req_valid = (st == S_FILL);
  assign refill_req_addr  = cur;

  a_r3_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vb_hit));
  a_r4_swap_one_late: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SWAP) |-> $past(st == S_CHECK) && !refill_req_valid);
  a_r6_refill_held: assert property (@(posedge clk) disable iff (!rst_n)
    refill_req_valid && !refill_resp_valid |=> refill_req_valid && $stable(refill_req_addr));
  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid |=> !stall);
  a_r9_one_oldest: assert property (@(posedge clk) disable iff (!rst_n)
    !any_free |-> $countones(vb_old) == 1);
endmodule

// File: tb/tb_vc_cache.sv
module tb_vc_cache;
  localparam int AW = 12, IDX_W = 3, DW = 32, VB_N = 4, LAT = 3;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0;
  logic [AW-1:0] req_addr = '0;
  logic stall, resp_valid, refill_req_valid;
  logic [DW-1:0] resp_data;
  logic [AW-1:0] refill_req_addr;
  logic refill_resp_valid = 0;
  logic [DW-1:0] refill_resp_data = '0;

  vc_cache #(.AW(AW), .IDX_W(IDX_W), .DW(DW), .VB_N(VB_N)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .stall(stall), .resp_valid(resp_valid), .resp_data(resp_data),
    .refill_req_valid(refill_req_valid), .refill_req_addr(refill_req_addr),
    .refill_resp_valid(refill_resp_valid), .refill_resp_data(refill_resp_data));

  always #2 clk = ~clk;

  int checks = 0, fails = 0;
  bit done = 0;

  function automatic logic [DW-1:0] mem(int a);
    return DW'(a * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
  endfunction

  task automatic chk(bit ok, string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  int rcnt = 0;
  always @(negedge clk) begin
    if (refill_req_valid && !refill_resp_valid) begin
      rcnt++;
      if (rcnt == LAT) begin
        refill_resp_valid = 1;
        refill_resp_data  = mem(int'(refill_req_addr));
      end
    end else begin
      refill_resp_valid = 0;
      rcnt = 0;
    end
  end

  int m_line [1 << IDX_W];
  int vq [$];

  task automatic access(int a, bit noise);
    int s, cls, exp_k, pos;
    string tag;
    s = a % (1 << IDX_W);
    pos = -1;
    foreach (vq[i]) if (vq[i] == a) pos = i;
    if (m_line[s] == a) cls = 0;
    else if (pos >= 0) cls = 1;
    else cls = 2;
    exp_k = (cls == 0) ? 1 : (cls == 1) ? 2 : 1 + LAT;
    tag = (cls == 0) ? "R2 R11 hit" : (cls == 1) ? "R3 R4 R5 victim" : "R6 R7 R8 R9 miss";
    @(negedge clk); #1;
    chk(!stall && !resp_valid, "R10 idle before request", {stall, resp_valid}, 0);
    req_valid = 1; req_addr = AW'(a);
    for (int k = 1; k <= exp_k; k++) begin
      @(negedge clk); #1;
      if (noise && k < exp_k) begin req_valid = 1; req_addr = AW'(a ^ 9); end
      else req_valid = 0;
      chk(stall === 1'b1, "R10 stall while busy", stall, 1);
      chk(resp_valid === (k == exp_k), tag, resp_valid, (k == exp_k));
      chk(refill_req_valid === (cls == 2 && k >= 2), "R6 refill request", refill_req_valid, (cls == 2 && k >= 2));
      if (cls == 2 && k >= 2)
        chk(refill_req_addr === AW'(a), "R6 refill address", refill_req_addr, a);
      if (k == exp_k)
        chk(resp_data === mem(a), tag, resp_data, mem(a));
    end
    if (cls == 1) begin
      vq.delete(pos);
      vq.push_back(m_line[s]);
      m_line[s] = a;
    end else if (cls == 2) begin
      if (m_line[s] >= 0) begin
        vq.push_back(m_line[s]);
        if (vq.size() > VB_N) void'(vq.pop_front());
      end
      m_line[s] = a;
    end
  endtask

  function automatic int L(int t, int s);
    return t * (1 << IDX_W) + s;
  endfunction

  initial begin
    #(4 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] lfsr;
    foreach (m_line[i]) m_line[i] = -1;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    chk(!stall && !resp_valid && !refill_req_valid, "R1 reset outputs",
        {stall, resp_valid, refill_req_valid}, 0);
    rst_n = 1;
    access(L(1, 0), 0);
    access(L(1, 0), 0);
    access(L(2, 0), 0);
    access(L(1, 0), 1);
    access(L(1, 0), 0);
    access(L(2, 0), 0);
    for (int t = 3; t <= 7; t++) access(L(t, 0), t[0]);
    access(L(1, 0), 0);
    access(L(4, 0), 0);
    for (int s = 1; s < (1 << IDX_W); s++) access(L(s + 20, s), 0);
    access(L(5, 0), 0);
    access(L(511, 7), 1);
    access(L(511, 7), 0);
    access(L(0, 7), 0);
    access(L(511, 7), 0);
    lfsr = 32'hACE1_1234;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      access(L(int'(lfsr[7:4]) % 6, int'(lfsr[9])), (n % 3) == 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule